// File: doc/BRIEF.md
# Pulse Add-Subtract Clock Trimmer

This block turns a stream of oscillator enable ticks, one for each cycle of a 32.768 kHz crystal, into a corrected one-second tick. It counts oscillator ticks, and the length of each second is the nominal count adjusted by a signed coarse trim code. A positive code removes that many oscillator cycles from the second, so the clock runs faster. A negative code adds cycles, so the clock runs slower. Each step moves the rate by one cycle per second, which is about 30.5 ppm. The useful range is ten steps either way. The correction works only by inserting or removing whole counts. It never acts on the oscillator itself.

The trim code is latched only when a second completes, so every second runs with one consistent correction. A frequency tap lets the result be measured. It can show one of four things:
- the untrimmed oscillator ticks;
- the trimmed one-second tick;
- a faster tick derived from the same trimmed counter;
- nothing (held low).

Top module: `pulse_trim_divider`

## Requirements
- R1: After reset, secTick and freqOut are 0 and the latched trim is zero, so the first second lasts exactly NOM_CYCLES oscillator ticks, whatever trimCode holds during reset.
- R2: With a latched code of 0, consecutive secTick pulses are separated by exactly NOM_CYCLES oscillator ticks.
- R3: With a latched positive code k, where k is at most MAX_STEPS, a second lasts NOM_CYCLES - k oscillator ticks.
- R4: With a latched negative code -k, where k is at most MAX_STEPS, a second lasts NOM_CYCLES + k oscillator ticks.
- R5: trimCode is a two's-complement value of TRIM_W bits. When it is above +MAX_STEPS or below -MAX_STEPS, it is saturated to that limit when latched.
- R6: trimCode is sampled only in the clock cycle whose oscillator tick completes a second, and that value sets the length of the next second. Changes made at any other time have no effect on second length.
- R7: secTick is a single-cycle pulse. It is asserted in the clock cycle right after the clock cycle whose oscillator tick completes the second.
- R8: With outSel = 0, freqOut repeats oscTick one clock later, unaffected by the trim code.
- R9: With outSel = 1, freqOut equals secTick.
- R10: With outSel = 2, freqOut pulses one clock after every FAST_DIV-th oscillator tick counted from the start of the second. It also pulses after the last tick of a trimmed second, so every second starts the fast pattern afresh.
- R11: With outSel = 3, freqOut stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscTick | input | 1 | One-cycle enable for each oscillator cycle |
| trimCode | input | TRIM_W | Signed coarse trim, in oscillator cycles per second |
| outSel | input | 2 | Frequency tap select: 0 raw, 1 one second, 2 fast, 3 off |
| secTick | output | 1 | Corrected one-second pulse |
| freqOut | output | 1 | Frequency tap pulse stream |

## Verification
The bench builds the block with NOM_CYCLES = 64, FAST_DIV = 8, MAX_STEPS = 10 and TRIM_W = 6. With these values every trim code, including both saturation limits and out-of-range codes down to -32, can be exercised over dozens of whole seconds in a short run. A second of 54 to 74 ticks is not a multiple of 8, so the shortened final fast segment of R10 is reached in most seconds. Oscillator gaps are randomised, and trimCode changes in the middle of each second to show that only the value present at the boundary is used.

// File: rtl/pulse_trim_pkg.sv
package pulse_trim_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;  // one oscillator tick counted
    logic wrap;     // second complete: clear count, latch code
  } trimStrobe_t;

  typedef enum logic [1:0] {
    SEL_RAW  = 2'd0,
    SEL_SEC  = 2'd1,
    SEL_FAST = 2'd2,
    SEL_OFF  = 2'd3
  } tapSel_e;

endpackage

// File: rtl/trim_counter_dp.sv
module trim_counter_dp
  import pulse_trim_pkg::*;
#(
  parameter int NOM_CYCLES = 32768,
  parameter int MAX_STEPS  = 10,
  parameter int TRIM_W     = 6,
  parameter int FAST_DIV   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [TRIM_W-1:0] trimCode,
  input  trimStrobe_t              strb,
  output logic                     lastCycle,
  output logic                     fastHit
);

  localparam int CNT_W    = $clog2(NOM_CYCLES + MAX_STEPS + 1);
  localparam int FAST_LOG = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
  localparam logic [CNT_W-1:0] NOM_LAST = CNT_W'(NOM_CYCLES - 1);
  localparam logic signed [TRIM_W-1:0] POS_LIM = TRIM_W'(MAX_STEPS);
  localparam logic signed [TRIM_W-1:0] NEG_LIM = -POS_LIM;

  logic [CNT_W-1:0]         tickCnt;
  logic signed [TRIM_W-1:0] codeReg;
  logic signed [TRIM_W-1:0] satCode;
  logic [CNT_W-1:0]         lastIdx;

  always_comb begin
    if (trimCode > POS_LIM)      satCode = POS_LIM;
    else if (trimCode < NEG_LIM) satCode = NEG_LIM;
    else                         satCode = trimCode;
  end

  // Index of the final tick of the current second (modular sign extension)
  assign lastIdx   = NOM_LAST - {{(CNT_W-TRIM_W){codeReg[TRIM_W-1]}}, codeReg};
  assign lastCycle = (tickCnt == lastIdx);

  generate
    if (FAST_DIV > 1) begin : g_fastDiv
      assign fastHit = (tickCnt[FAST_LOG-1:0] == {FAST_LOG{1'b1}});
    end else begin : g_fastAll
      assign fastHit = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      codeReg <= '0;
    end else if (strb.wrap) begin
      tickCnt <= '0;
      codeReg <= satCode;
    end else if (strb.advance) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl
  import pulse_trim_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        oscTick,
  input  logic [1:0]  outSel,
  input  logic        lastCycle,
  input  logic        fastHit,
  output trimStrobe_t strb,
  output logic        secTick,
  output logic        freqOut
);

  logic    tapNext;
  tapSel_e tapSel;

  assign tapSel       = tapSel_e'(outSel);
  assign strb.advance = oscTick;
  assign strb.wrap    = oscTick & lastCycle;

  always_comb begin
    unique case (tapSel)
      SEL_RAW:  tapNext = oscTick;
      SEL_SEC:  tapNext = strb.wrap;
      SEL_FAST: tapNext = oscTick & (fastHit | lastCycle);
      default:  tapNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secTick <= 1'b0;
      freqOut <= 1'b0;
    end else begin
      secTick <= strb.wrap;
      freqOut <= tapNext;
    end
  end

endmodule

// File: rtl/pulse_trim_divider.sv
module pulse_trim_divider
  import pulse_trim_pkg::*;
#(
  parameter int NOM_CYCLES = 32768,
  parameter int MAX_STEPS  = 10,
  parameter int TRIM_W     = 6,
  parameter int FAST_DIV   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     oscTick,
  input  logic signed [TRIM_W-1:0] trimCode,
  input  logic [1:0]               outSel,
  output logic                     secTick,
  output logic                     freqOut
);

  trimStrobe_t strb;
  logic        lastCycle;
  logic        fastHit;

  trim_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .oscTick   (oscTick),
    .outSel    (outSel),
    .lastCycle (lastCycle),
    .fastHit   (fastHit),
    .strb      (strb),
    .secTick   (secTick),
    .freqOut   (freqOut)
  );

  trim_counter_dp #(
    .NOM_CYCLES (NOM_CYCLES),
    .MAX_STEPS  (MAX_STEPS),
    .TRIM_W     (TRIM_W),
    .FAST_DIV   (FAST_DIV)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .trimCode  (trimCode),
    .strb      (strb),
    .lastCycle (lastCycle),
    .fastHit   (fastHit)
  );

endmodule

// File: rtl/pulse_trim_divider_chk.sv
module pulse_trim_divider_chk #(
  parameter int NOM_CYCLES = 32768,
  parameter int MAX_STEPS  = 10
) (
  input logic       clk,
  input logic       rstN,
  input logic       oscTick,
  input logic [1:0] outSel,
  input logic       secTick,
  input logic       freqOut
);

  int oscCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        oscCount <= 0;
    else if (secTick) oscCount <= oscTick ? 1 : 0;
    else if (oscTick) oscCount <= oscCount + 1;
  end

  // R3 R4 R5: second length stays within the saturated trim window
  a_r5_len_bounds: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> (oscCount >= NOM_CYCLES - MAX_STEPS && oscCount <= NOM_CYCLES + MAX_STEPS));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> !secTick);

  a_r7_after_osc: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && secTick) |-> $past(oscTick));

  a_r8_raw_follow: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(outSel) == 2'd0) |-> (freqOut == $past(oscTick)));

  a_r9_sec_follow: assert property (@(posedge clk) disable iff (!rstN)
    ($past(outSel) == 2'd1) |-> (freqOut == secTick));

  a_r11_off_low: assert property (@(posedge clk) disable iff (!rstN)
    ($past(outSel) == 2'd3) |-> !freqOut);

endmodule

bind pulse_trim_divider pulse_trim_divider_chk #(
  .NOM_CYCLES (NOM_CYCLES),
  .MAX_STEPS  (MAX_STEPS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .oscTick (oscTick),
  .outSel  (outSel),
  .secTick (secTick),
  .freqOut (freqOut)
);

// File: tb/pulse_trim_divider_bench.sv
module pulse_trim_divider_bench;

  localparam int NOM = 64;
  localparam int MAXS = 10;
  localparam int TW = 6;
  localparam int FD = 8;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 oscTick = 1'b0;
  logic signed [TW-1:0] trimCode = 6'sd7;
  logic [1:0]           outSel = 2'd0;
  logic                 secTick;
  logic                 freqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pulse_trim_divider #(
    .NOM_CYCLES (NOM), .MAX_STEPS (MAXS), .TRIM_W (TW), .FAST_DIV (FD)
  ) u_pulse_trim_divider (
    .clk (clk), .rstN (rstN), .oscTick (oscTick), .trimCode (trimCode),
    .outSel (outSel), .secTick (secTick), .freqOut (freqOut)
  );

  function automatic int clampCode(int c);
    if (c > MAXS) return MAXS;
    if (c < -MAXS) return -MAXS;
    return c;
  endfunction

  function automatic int expLen(int c);
    return NOM - clampCode(c);
  endfunction

  function automatic string lenTag(int c);
    if (c > MAXS || c < -MAXS) return "R5";
    if (c > 0) return "R3";
    if (c < 0) return "R4";
    return "R2";
  endfunction

  function automatic int dirCode(int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return -1;
      3: return 10;
      4: return -10;
      5: return 11;
      6: return -12;
      7: return 31;
      8: return -32;
      default: return 5;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One oscillator tick, then gap idle cycles; samples after the capture edge
  task automatic oscPulse(int gap, output bit t, output bit f, output bit t2, output bit f2);
    @(negedge clk) oscTick = 1'b1;
    @(negedge clk) oscTick = 1'b0;
    t = secTick; f = freqOut;
    @(negedge clk);
    t2 = secTick; f2 = freqOut;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic runSecond(int sel, int nextCode, output int len);
    bit t, f, t2, f2, expF;
    int k = 0;
    bit done = 1'b0;
    outSel = 2'(sel);
    trimCode = TW'($urandom % 64);  // junk during the second, R6
    while (!done && k < 200) begin
      oscPulse(1 + int'($urandom % 3), t, f, t2, f2);
      k++;
      if (k == 2) trimCode = TW'(nextCode);
      case (sel)
        0: expF = 1'b1;
        1: expF = t;
        2: expF = (k % FD == 0) || t;
        default: expF = 1'b0;
      endcase
      check(f == expF, (sel == 0) ? "R8" : (sel == 1) ? "R9" : (sel == 2) ? "R10" : "R11",
            int'(f), int'(expF));
      check(t2 == 1'b0 && f2 == 1'b0, "R7 single-cycle", int'(t2 | f2), 0);
      done = t;
    end
    len = k;
  endtask

  initial begin
    int len;
    int latched;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    check(secTick == 1'b0, "R1 secTick reset", int'(secTick), 0);
    check(freqOut == 1'b0, "R1 freqOut reset", int'(freqOut), 0);
    rstN = 1'b1;
    runSecond(1, dirCode(0), len);
    check(len == NOM, "R1 first second nominal", len, NOM);
    latched = dirCode(0);
    for (int i = 1; i < 34; i++) begin
      int nc = (i < 9) ? dirCode(i) : int'($urandom % 64) - 32;
      runSecond(i % 4, nc, len);
      check(len == expLen(latched), $sformatf("%s R6 code=%0d", lenTag(latched), latched),
            len, expLen(latched));
      latched = nc;
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule